// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply and multiply-accumulate datapath of a processor core. It holds a 64-bit accumulator made of a high word and a low word. An operation starts with an operation code, two 32-bit operands that are already loaded, and a saturation flag. The unit then updates the accumulator with a plain product, a full-width product, or a product added to the accumulator. In saturating mode the add clamps instead of wrapping.

The unit takes two cycles per operation. In the first cycle it forms the product into a register. In the second cycle it folds that product into the accumulator and pulses `done_o`. The core can also write either accumulator word directly through a load port, or zero the whole accumulator with a clear strobe. Both words can be read at any time.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulator words read zero, and `busy_o` and `done_o` are low.
- R2: A `start_i` seen while `busy_o` is low is accepted. `busy_o` is then high for exactly one cycle, and in the cycle after that `done_o` is high for one cycle with the result already visible. A `start_i` seen while `busy_o` is high is ignored.
- R3: The 32-bit multiply (op 0), the unsigned 16-bit multiply (op 1, zero-extended low halves) and the signed 16-bit multiply (op 2, sign-extended low halves) write the low 32 product bits to the low word and leave the high word unchanged.
- R4: The unsigned 32x32 multiply (op 3) and the signed 32x32 multiply (op 4) write the whole 64-bit product to high:low.
- R5: The signed 32-bit multiply-accumulate (op 5) with saturation off adds the 64-bit signed product to the accumulator, wrapping modulo 2^64.
- R6: Op 5 with saturation on adds the product to the accumulator sign-extended from bit 47. It clamps the sum to [-2^47, 2^47-1], writes only accumulator bits 47:0, and keeps bits 63:48.
- R7: The signed 16-bit multiply-accumulate (op 6) with saturation off adds the sign-extended 32-bit product to the full 64-bit accumulator.
- R8: Op 6 with saturation on adds the product to the low word taken as signed 32-bit. On overflow it writes 0x7FFFFFFF or 0x80000000 to the low word and sets bit 0 of the high word. Without overflow it writes the sum and leaves the high word unchanged.
- R9: `load_hi_i` or `load_lo_i` writes `load_data_i` into that word, and `clear_i` zeroes both words. Clear wins over loads, and a load wins over the result write for its word in the same cycle.
- R10: Op 7 is accepted and completes with a `done_o` pulse but leaves the accumulator unchanged.
- R11: The saturation flag and the op code are sampled when `start_i` is accepted. Changing `sat_i` during `busy_o` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation |
| op_i | input | 3 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| sat_i | input | 1 | Saturation mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result written last edge |
| load_hi_i | input | 1 | Write high word |
| load_lo_i | input | 1 | Write low word |
| clear_i | input | 1 | Zero accumulator |
| load_data_i | input | 32 | Data for word loads |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |

## Verification
The hardest case to reach is 48-bit saturation when the accumulator's top 16 bits differ from the sign of bit 47. In that case the clamp must act on the sign-extended view while the stored upper bits stay as they were. Random products cannot get the accumulator near the 48-bit edge. The bench therefore preloads the high and low words through the load port with values next to the limit and with unrelated upper bits, then issues a small saturating accumulate in each direction. Random stimulus is biased toward extreme operands so that 32-bit overflow of the 16-bit accumulate occurs often.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL32  = 3'd0,
    OP_MULU16 = 3'd1,
    OP_MULS16 = 3'd2,
    OP_DMULU  = 3'd3,
    OP_DMULS  = 3'd4,
    OP_MACL   = 3'd5,
    OP_MACW   = 3'd6,
    OP_NONE   = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  mac_op_e op_i,
  input  logic    sat_i,
  output logic    go_o,
  output logic    busy_o,
  output logic    done_o,
  output mac_op_e op_o,
  output logic    sat_o
);
  logic busy_q, done_q, sat_q;
  mac_op_e op_q;

  assign go_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NONE;
      sat_q  <= 1'b0;
    end else begin
      busy_q <= go_o;
      done_q <= busy_q;
      if (go_o) begin
        op_q  <= op_i;
        sat_q <= sat_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;
  assign sat_o  = sat_q;
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int W = 32,
  parameter int H = W / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_i,
  input  mac_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] ea, eb, prod_d;
  logic [PW-1:0] prod_q;

  // widen operands so one signed multiplier serves every variant
  always_comb begin
    unique case (op_i)
      OP_MULU16: begin
        ea = {{(PW-H){1'b0}}, a_i[H-1:0]};
        eb = {{(PW-H){1'b0}}, b_i[H-1:0]};
      end
      OP_MULS16, OP_MACW: begin
        ea = {{(PW-H){a_i[H-1]}}, a_i[H-1:0]};
        eb = {{(PW-H){b_i[H-1]}}, b_i[H-1:0]};
      end
      OP_DMULU: begin
        ea = {{W{1'b0}}, a_i};
        eb = {{W{1'b0}}, b_i};
      end
      default: begin
        ea = {{W{a_i[W-1]}}, a_i};
        eb = {{W{b_i[W-1]}}, b_i};
      end
    endcase
  end

  assign prod_d = ea * eb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prod_q <= '0;
    else if (cap_i) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int W     = 32,
  parameter int SAT_W = 48
) (
  input  mac_op_e        op_i,
  input  logic           sat_i,
  input  logic [2*W-1:0] acc_i,
  input  logic [2*W-1:0] prod_i,
  output logic [2*W-1:0] acc_o
);
  localparam int PW = 2 * W;
  localparam logic signed [PW:0] LMAX = {{(PW+2-SAT_W){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [PW:0] LMIN = ~LMAX;
  localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

  // wide accumulate with clamp at SAT_W bits
  logic signed [PW:0] acc_sx, prod_sx, lsum;
  logic [SAT_W-1:0]   lclamp;
  assign acc_sx  = {{(PW+1-SAT_W){acc_i[SAT_W-1]}}, acc_i[SAT_W-1:0]};
  assign prod_sx = {prod_i[PW-1], prod_i};
  assign lsum    = acc_sx + prod_sx;
  always_comb begin
    if (lsum > LMAX)      lclamp = LMAX[SAT_W-1:0];
    else if (lsum < LMIN) lclamp = LMIN[SAT_W-1:0];
    else                  lclamp = lsum[SAT_W-1:0];
  end

  // narrow accumulate with clamp at W bits
  logic [PW-1:0] pw_ext;
  logic [W:0]    wsum;
  logic          wovf;
  assign pw_ext = {{W{prod_i[W-1]}}, prod_i[W-1:0]};
  assign wsum   = {acc_i[W-1], acc_i[W-1:0]} + {prod_i[W-1], prod_i[W-1:0]};
  assign wovf   = wsum[W] ^ wsum[W-1];

  always_comb begin
    acc_o = acc_i;
    unique case (op_i)
      OP_MUL32, OP_MULU16, OP_MULS16: acc_o = {acc_i[PW-1:W], prod_i[W-1:0]};
      OP_DMULU, OP_DMULS:             acc_o = prod_i;
      OP_MACL: begin
        if (sat_i) acc_o = {acc_i[PW-1:SAT_W], lclamp};
        else       acc_o = acc_i + prod_i;
      end
      OP_MACW: begin
        if (!sat_i)    acc_o = acc_i + pw_ext;
        else if (wovf) acc_o = {acc_i[PW-1:W+1], 1'b1, (wsum[W] ? WMIN : WMAX)};
        else           acc_o = {acc_i[PW-1:W], wsum[W-1:0]};
      end
      default: acc_o = acc_i;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W     = 32,
  parameter int SAT_W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sat_i,
  output logic         busy_o,
  output logic         done_o,
  input  logic         load_hi_i,
  input  logic         load_lo_i,
  input  logic         clear_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o
);
  logic          go;
  mac_op_e       op_q;
  logic          sat_q;
  logic [2*W-1:0] prod, acc_nxt;
  logic [W-1:0]  hi_q, lo_q;

  mac_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_i   (mac_op_e'(op_i)),
    .sat_i  (sat_i),
    .go_o   (go),
    .busy_o (busy_o),
    .done_o (done_o),
    .op_o   (op_q),
    .sat_o  (sat_q)
  );

  mac_mult #(.W(W)) u_mult (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (go),
    .op_i  (mac_op_e'(op_i)),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .prod_o(prod)
  );

  mac_accum #(.W(W), .SAT_W(SAT_W)) u_accum (
    .op_i  (op_q),
    .sat_i (sat_q),
    .acc_i ({hi_q, lo_q}),
    .prod_i(prod),
    .acc_o (acc_nxt)
  );

  // clear > word load > result write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (clear_i) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (load_hi_i)   hi_q <= load_data_i;
      else if (busy_o) hi_q <= acc_nxt[2*W-1:W];
      if (load_lo_i)   lo_q <= load_data_i;
      else if (busy_o) lo_q <= acc_nxt[W-1:0];
    end
  end

  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int W     = 32,
  parameter int SAT_W = 48
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy_o,
  input logic         done_o,
  input logic         load_hi_i,
  input logic         load_lo_i,
  input logic         clear_i,
  input logic [W-1:0] load_data_i,
  input logic [W-1:0] acc_hi_o,
  input logic [W-1:0] acc_lo_o,
  input mac_op_e      op_q,
  input logic         sat_q
);
  localparam int KEEP = SAT_W - W;

  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  assert_busy_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_hi_o == '0 && acc_lo_o == '0));
  assert_load_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_lo_i && !clear_i) |=> acc_lo_o == $past(load_data_i));
  assert_load_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_hi_i && !clear_i) |=> acc_hi_o == $past(load_data_i));
  assert_narrow_keeps_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (op_q == OP_MUL32 || op_q == OP_MULU16 || op_q == OP_MULS16)
     && !clear_i && !load_hi_i) |=> $stable(acc_hi_o));
  assert_sat_keeps_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_MACL && sat_q && !clear_i && !load_hi_i)
    |=> acc_hi_o[W-1:KEEP] == $past(acc_hi_o[W-1:KEEP]));
  assert_none_no_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_NONE && !clear_i && !load_hi_i && !load_lo_i)
    |=> ($stable(acc_hi_o) && $stable(acc_lo_o)));
endmodule

bind mac_unit mac_unit_chk #(.W(W), .SAT_W(SAT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .load_hi_i  (load_hi_i),
  .load_lo_i  (load_lo_i),
  .clear_i    (clear_i),
  .load_data_i(load_data_i),
  .acc_hi_o   (acc_hi_o),
  .acc_lo_o   (acc_lo_o),
  .op_q       (op_q),
  .sat_q      (sat_q)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, sat = 0, ld_hi = 0, ld_lo = 0, clr = 0;
  logic [2:0] op = 3'd7;
  logic [31:0] a = 0, b = 0, ld_data = 0;
  logic busy, done;
  logic [31:0] hi, lo;
  logic [63:0] mdl = 64'd0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mac_unit i_mac_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .opa_i(a), .opb_i(b),
    .sat_i(sat), .busy_o(busy), .done_o(done), .load_hi_i(ld_hi), .load_lo_i(ld_lo),
    .clear_i(clr), .load_data_i(ld_data), .acc_hi_o(hi), .acc_lo_o(lo));

  function automatic logic [63:0] model(input logic [63:0] acc, input logic [2:0] o,
                                        input logic [31:0] x, input logic [31:0] y, input logic s);
    longint p, sm;
    logic [63:0] r;
    r = acc;
    case (o)
      3'd0: r[31:0] = x * y;
      3'd1: r[31:0] = {16'd0, x[15:0]} * {16'd0, y[15:0]};
      3'd2: begin p = longint'($signed(x[15:0])) * longint'($signed(y[15:0])); r[31:0] = p[31:0]; end
      3'd3: r = {32'd0, x} * {32'd0, y};
      3'd4: r = longint'($signed(x)) * longint'($signed(y));
      3'd5: begin
        p = longint'($signed(x)) * longint'($signed(y));
        if (!s) r = acc + p;
        else begin
          sm = p + $signed({{16{acc[47]}}, acc[47:0]});
          if (sm > 64'sh00007FFFFFFFFFFF) sm = 64'sh00007FFFFFFFFFFF;
          else if (sm < -64'sh0000800000000000) sm = -64'sh0000800000000000;
          r = {acc[63:48], sm[47:0]};
        end
      end
      3'd6: begin
        p = longint'($signed(x[15:0])) * longint'($signed(y[15:0]));
        if (!s) r = acc + p;
        else begin
          sm = longint'($signed(acc[31:0])) + p;
          if (sm > 64'sh7FFFFFFF) begin r[31:0] = 32'h7FFFFFFF; r[32] = 1'b1; end
          else if (sm < -64'sh80000000) begin r[31:0] = 32'h80000000; r[32] = 1'b1; end
          else r[31:0] = sm[31:0];
        end
      end
      default: r = acc;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // full op: optional hold of start, sat flip and side strobes during the busy cycle
  task automatic issue(input string tag, input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic s, input bit hold = 0,
                       input bit flip = 0, input bit lh = 0, input bit ll = 0,
                       input bit cl = 0, input logic [31:0] d = 0);
    logic [63:0] exp;
    @(negedge clk);
    start = 1; op = o; a = x; b = y; sat = s;
    @(negedge clk);
    check({tag, " busy"}, {63'd0, busy}, 64'd1);
    start = hold;
    if (hold) begin op = 3'd3; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
    if (flip) sat = ~s;
    ld_hi = lh; ld_lo = ll; clr = cl; ld_data = d;
    @(negedge clk);
    start = 0; ld_hi = 0; ld_lo = 0; clr = 0;
    exp = model(mdl, o, x, y, s);
    if (cl) exp = 64'd0;
    else begin
      if (lh) exp[63:32] = d;
      if (ll) exp[31:0] = d;
    end
    mdl = exp;
    check({tag, " done"}, {62'd0, done, busy}, 64'd2);
    check(tag, {hi, lo}, exp);
  endtask

  task automatic load(input bit h, input logic [31:0] d);
    @(negedge clk);
    ld_hi = h; ld_lo = !h; ld_data = d;
    @(negedge clk);
    ld_hi = 0; ld_lo = 0;
    if (h) mdl[63:32] = d; else mdl[31:0] = d;
    check("R9 load", {hi, lo}, mdl);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0000_7FFF;
      3: return 32'hFFFF_8000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset", {hi, lo, 30'd0, busy, done}, 96'd0);
    rst_n = 1;

    // directed
    load(1, 32'hDEAD_BEEF);
    issue("R3 mul32", 3'd0, 32'h1234_5678, 32'h9ABC_DEF0, 0);
    issue("R3 mulu16", 3'd1, 32'hAAAA_FFFF, 32'h5555_FFFF, 0);
    issue("R3 muls16", 3'd2, 32'h0000_FFFF, 32'h0000_8000, 0);
    issue("R4 dmulu", 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    issue("R4 dmuls", 3'd4, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    issue("R5 macl wrap", 3'd5, 32'h8000_0000, 32'h8000_0000, 0);
    // 48-bit clamp with foreign upper bits, both directions
    load(1, 32'hABCD_7FFF); load(0, 32'hFFFF_FFF0);
    issue("R6 macl sat hi", 3'd5, 32'd100, 32'd1, 1);
    load(1, 32'h1234_8000); load(0, 32'h0000_0010);
    issue("R6 macl sat lo", 3'd5, 32'hFFFF_FF00, 32'd1, 1);
    load(1, 32'h0000_7FFF); load(0, 32'hFFFF_FF00);
    issue("R11 sat sampled", 3'd5, 32'd1000, 32'd1, 1, 0, 1);
    load(1, 32'h0000_0000); load(0, 32'hFFFF_FFFF);
    issue("R7 macw", 3'd6, 32'h0000_7FFF, 32'h0000_0002, 0);
    load(1, 32'h0000_0010); load(0, 32'h7FFF_FFF0);
    issue("R8 macw ovf", 3'd6, 32'h0000_7FFF, 32'h0000_7FFF, 1);
    load(1, 32'h0000_0010); load(0, 32'h8000_0010);
    issue("R8 macw neg ovf", 3'd6, 32'h0000_8000, 32'h0000_7FFF, 1);
    issue("R8 macw no ovf", 3'd6, 32'h0000_0003, 32'h0000_0004, 1);
    issue("R10 none", 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    issue("R2 start ignored", 3'd0, 32'd3, 32'd5, 0, 1);
    issue("R9 load wins", 3'd3, 32'hFFFF_0000, 32'h0001_0000, 0, 0, 0, 0, 1, 0, 32'hCAFE_F00D);
    issue("R9 clear wins", 3'd4, 32'h1234_5678, 32'h1111_1111, 0, 0, 0, 1, 1, 1, 32'h5555_5555);

    // random
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0) load($urandom % 2, pick());
      issue("R3-R8 random", 3'($urandom % 8), pick(), pick(), 1'($urandom % 2));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule